// File: doc/BRIEF.md
# Programmable Composite Sync Timing Generator

The block produces line and field timing for interlaced composite video on a 27 MHz pixel clock. It keeps a pixel position inside the line and a half-line index inside the frame. From these it produces a composite sync flag, a burst gate and an active-video flag. The sync flag covers normal line sync, equalising pulses and broad vertical pulses. Every pulse edge is an input value counted in clock periods, so the same logic serves 525-line (1716 clocks per line) and 625-line (1728 clocks per line) standards.

The generator can lock to timing codes decoded from an incoming digital video stream. A start-of-line strobe restarts the pixel count and a field-start strobe places the counters at a field boundary. In free-run mode it ignores both strobes and runs from the clock alone, which is what a black-and-burst output needs. Subcarrier generation and the summing of signal levels are left to the neighbouring blocks.

Top module: `sync_timing_gen`

## Requirements
- R1: After reset, h_pos, line_num and field are all 0.
- R2: h_pos counts by one each clock from 0 to 1715 (std_625=0) or 1727 (std_625=1), then returns to 0 while line_num increases by one.
- R3: The frame has 2×N half-lines, with N=525 or 625. The first half of line k is half-line 2k and its second half starts at h_pos=half_line. field is 1 from half-line N onward, so every line_num in the second field is at least N/2 rounded down.
- R4: Outside the vertical interval, sync_tip is high only in the first half of a line and only while h_pos < hsync_w.
- R5: With free_run=0, sof_strobe sends the counters, on the next clock, to h_pos=0 and either line 0 (sof_field=0) or the first complete line of field 2 (263 or 313, field=1). sol_strobe alone gives h_pos=0 on the next clock and moves line_num to the next line. sof_strobe takes priority over sol_strobe.
- R6: With free_run=1, sol_strobe and sof_strobe have no effect: h_pos still advances by one and line_num does not change.
- R7: Half-lines are counted from the start of each field (field-relative index 0). Indices 0–5 and 12–17 (525) or 0–4 and 10–14 (625) carry equalising pulses. On these half-lines, sync_tip is high while the position within the half-line is below eq_w.
- R8: Field-relative half-lines 6–11 (525) or 5–9 (625) carry broad pulses. Each broad pulse starts at its half-line start (h_pos=0 or h_pos=half_line), and sync_tip stays high while the position within the half-line is below broad_w.
- R9: burst_gate is high when h_pos is in [burst_on, burst_off) in the first half of a line, but only for field-relative half-lines at or after the vertical interval. It is low on every equalising or broad half-line. When burst_on ≥ hsync_w, burst_gate and sync_tip are never high together.
- R10: active_video is high when the field-relative half-line is at least 40 (525) or 50 (625) and h_pos is in [act_on, act_off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| std_625 | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| free_run | input | 1 | 1 ignores the stream strobes |
| sol_strobe | input | 1 | Start-of-line strobe from the stream decoder |
| sof_strobe | input | 1 | Field-start strobe from the stream decoder |
| sof_field | input | 1 | Field that sof_strobe starts (0 = first) |
| hsync_w | input | HW | Line sync width in clocks |
| half_line | input | HW | Position where the second half of a line starts |
| eq_w | input | HW | Equalising pulse width |
| broad_w | input | HW | Broad pulse width |
| burst_on | input | HW | Burst gate start position |
| burst_off | input | HW | Burst gate end position (exclusive) |
| act_on | input | HW | Active video start position |
| act_off | input | HW | Active video end position (exclusive) |
| sync_tip | output | 1 | High during any sync pulse |
| burst_gate | output | 1 | High during the burst window |
| active_video | output | 1 | High during picture content |
| h_pos | output | HW | Pixel position within the line |
| line_num | output | VW-1 | Line within the frame |
| field | output | 1 | 0 = first field, 1 = second field |

## Verification
A wrong pixel count shows at h_pos on the very next clock. It also moves every sync, burst and active edge by the same amount. A half-line index that is off by one puts an equalising pulse where a broad pulse belongs, or burst on a vertical-interval line. That error shows within one half-line, as a sync pulse that is too long or too short. The bench samples pulse edges and wrap points at known offsets after each alignment strobe. Any of these errors therefore appears as a wrong flag at a specific position.

// File: rtl/sync_timing_gen.sv
module sync_timing_gen #(
  parameter int HW     = 11,
  parameter int VW     = 11,
  parameter int LEN_A  = 1716,
  parameter int LEN_B  = 1728,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int GRP_A  = 6,
  parameter int GRP_B  = 5,
  parameter int VB_A   = 40,
  parameter int VB_B   = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_625,
  input  logic          free_run,
  input  logic          sol_strobe,
  input  logic          sof_strobe,
  input  logic          sof_field,
  input  logic [HW-1:0] hsync_w,
  input  logic [HW-1:0] half_line,
  input  logic [HW-1:0] eq_w,
  input  logic [HW-1:0] broad_w,
  input  logic [HW-1:0] burst_on,
  input  logic [HW-1:0] burst_off,
  input  logic [HW-1:0] act_on,
  input  logic [HW-1:0] act_off,
  output logic          sync_tip,
  output logic          burst_gate,
  output logic          active_video,
  output logic [HW-1:0] h_pos,
  output logic [VW-2:0] line_num,
  output logic          field
);

  logic [VW-1:0] hl;

  wire [HW-1:0] line_len = std_625 ? HW'(LEN_B) : HW'(LEN_A);
  wire [VW-1:0] nhalf    = std_625 ? VW'(LINES_B) : VW'(LINES_A);
  wire [VW-1:0] g1       = std_625 ? VW'(GRP_B) : VW'(GRP_A);
  wire [VW-1:0] vb       = std_625 ? VW'(VB_B) : VW'(VB_A);
  wire [VW:0]   frame_hl = {nhalf, 1'b0};

  wire          h_last   = h_pos >= line_len - HW'(1);
  wire [VW-1:0] nl_raw   = {hl[VW-1:1], 1'b0} + VW'(2);
  wire [VW-1:0] next_ln  = ({1'b0, nl_raw} >= frame_hl) ? '0 : nl_raw;
  wire [VW-1:0] f2_start = nhalf + VW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_pos <= '0;
      hl    <= '0;
    end else if (!free_run && sof_strobe) begin
      h_pos <= '0;
      hl    <= sof_field ? f2_start : '0;
    end else if (!free_run && sol_strobe) begin
      h_pos <= '0;
      hl    <= next_ln;
    end else if (h_last) begin
      h_pos <= '0;
      hl    <= next_ln;
    end else begin
      h_pos <= h_pos + HW'(1);
      if (h_pos == half_line - HW'(1)) hl <= hl + VW'(1);
    end
  end

  assign field    = hl >= nhalf;
  assign line_num = hl[VW-1:1];

  wire [VW-1:0] fh     = field ? hl - nhalf : hl;
  wire          second = hl[0];
  wire [HW-1:0] seg    = second ? h_pos - half_line : h_pos;
  wire          broad  = (fh >= g1) && (fh < (g1 << 1));
  wire          vert   = fh < (g1 * VW'(3));
  wire          equ    = vert && !broad;

  assign sync_tip     = broad ? (seg < broad_w) :
                        equ   ? (seg < eq_w) :
                                (!second && h_pos < hsync_w);
  assign burst_gate   = !vert && !second && h_pos >= burst_on && h_pos < burst_off;
  assign active_video = fh >= vb && h_pos >= act_on && h_pos < act_off;

  a_r2_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(std_625) |-> h_pos < line_len);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && h_pos == line_len - HW'(1)) |=> h_pos == '0);

  a_r3_field_lines: assert property (@(posedge clk) disable iff (!rst_n)
    field |-> line_num >= nhalf[VW-1:1]);

  a_r5_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && (sol_strobe || sof_strobe)) |=> h_pos == '0);

  a_r6_free_count: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && h_pos < line_len - HW'(1)) |=> h_pos == $past(h_pos) + HW'(1));

  a_r9_burst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_gate && burst_on >= hsync_w) |-> !sync_tip);

endmodule

// File: tb/sync_timing_gen_tb_top.sv
module sync_timing_gen_tb_top;
  localparam int CLK_NS = 37;

  logic clk = 0, rst_n = 0, std_625 = 0, free_run = 0;
  logic sol_strobe = 0, sof_strobe = 0, sof_field = 0;
  logic [10:0] hsync_w, half_line, eq_w, broad_w, burst_on, burst_off, act_on, act_off;
  logic sync_tip, burst_gate, active_video, field;
  logic [10:0] h_pos;
  logic [9:0] line_num;

  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  sync_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .std_625(std_625), .free_run(free_run),
    .sol_strobe(sol_strobe), .sof_strobe(sof_strobe), .sof_field(sof_field),
    .hsync_w(hsync_w), .half_line(half_line), .eq_w(eq_w), .broad_w(broad_w),
    .burst_on(burst_on), .burst_off(burst_off), .act_on(act_on), .act_off(act_off),
    .sync_tip(sync_tip), .burst_gate(burst_gate), .active_video(active_video),
    .h_pos(h_pos), .line_num(line_num), .field(field));

  // {realign, std, fld, line offset[4:0], h[10:0], sync, burst, active, req[3:0]}
  localparam int NV = 28;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,5'd0, 11'd10,  3'b100,4'd7},  // R7 equalising on
    {1'b0,1'b0,1'b0,5'd0, 11'd100, 3'b000,4'd7},  // R7 past eq_w
    {1'b0,1'b0,1'b0,5'd0, 11'd868, 3'b100,4'd7},  // R7 second half
    {1'b0,1'b0,1'b0,5'd3, 11'd700, 3'b100,4'd8},  // R8 broad
    {1'b0,1'b0,1'b0,5'd3, 11'd800, 3'b000,4'd8},  // R8 after broad_w
    {1'b0,1'b0,1'b0,5'd4, 11'd1558,3'b100,4'd8},  // R8 second broad
    {1'b0,1'b0,1'b0,5'd6, 11'd50,  3'b100,4'd7},  // R7 post-equalising
    {1'b0,1'b0,1'b0,5'd8, 11'd150, 3'b000,4'd9},  // R9 no burst eq line
    {1'b0,1'b0,1'b0,5'd9, 11'd100, 3'b100,4'd4},  // R4 line sync
    {1'b0,1'b0,1'b0,5'd9, 11'd150, 3'b010,4'd9},  // R9 burst
    {1'b0,1'b0,1'b0,5'd9, 11'd868, 3'b000,4'd4},  // R4 second half
    {1'b0,1'b0,1'b0,5'd19,11'd300, 3'b000,4'd10}, // R10 blanked line
    {1'b0,1'b0,1'b0,5'd20,11'd300, 3'b001,4'd10}, // R10 first active
    {1'b0,1'b0,1'b0,5'd20,11'd1700,3'b000,4'd10}, // R10 past act_off
    {1'b1,1'b0,1'b1,5'd0, 11'd10,  3'b100,4'd7},  // R7 field two
    {1'b0,1'b0,1'b1,5'd2, 11'd700, 3'b000,4'd7},  // R7
    {1'b0,1'b0,1'b1,5'd2, 11'd868, 3'b100,4'd8},  // R8
    {1'b0,1'b0,1'b1,5'd8, 11'd150, 3'b000,4'd9},  // R9
    {1'b0,1'b0,1'b1,5'd8, 11'd868, 3'b000,4'd4},  // R4
    {1'b0,1'b0,1'b1,5'd9, 11'd150, 3'b010,4'd9},  // R9
    {1'b1,1'b1,1'b0,5'd0, 11'd10,  3'b100,4'd7},  // R7 625
    {1'b0,1'b1,1'b0,5'd2, 11'd700, 3'b000,4'd7},  // R7
    {1'b0,1'b1,1'b0,5'd2, 11'd1564,3'b100,4'd8},  // R8
    {1'b0,1'b1,1'b0,5'd7, 11'd150, 3'b000,4'd9},  // R9
    {1'b0,1'b1,1'b0,5'd7, 11'd874, 3'b000,4'd4},  // R4
    {1'b0,1'b1,1'b0,5'd8, 11'd150, 3'b010,4'd9},  // R9
    {1'b0,1'b1,1'b0,5'd24,11'd300, 3'b000,4'd10}, // R10
    {1'b0,1'b1,1'b0,5'd25,11'd300, 3'b001,4'd10}  // R10
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_std(input logic s);
    std_625 = s;
    hsync_w = 127; eq_w = 63; broad_w = 737;
    burst_on = 143; burst_off = 210; act_on = 256;
    half_line = s ? 11'd864 : 11'd858;
    act_off   = s ? 11'd1708 : 11'd1696;
  endtask

  task automatic align(input logic s, input logic f);
    @(negedge clk);
    set_std(s);
    sof_field = f; sof_strobe = 1;
    @(posedge clk);
    @(negedge clk);
    sof_strobe = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int el;
    int len;
    set_std(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 h_pos", h_pos, 0);
    check("R1 line_num", line_num, 0);
    check("R1 field", field, 0);
    rst_n = 1;

    el = 0;
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      int tgt;
      v = VEC[i];
      len = v[24] ? 1728 : 1716;
      if (v[25]) begin
        align(v[24], v[23]);
        el = 0;
      end
      tgt = int'(v[22:18]) * len + int'(v[17:7]);
      repeat (tgt - el) @(posedge clk);
      el = tgt;
      @(negedge clk);
      check($sformatf("R%0d sync line+%0d h=%0d", v[3:0], v[22:18], v[17:7]), sync_tip, v[6]);
      check($sformatf("R%0d burst line+%0d h=%0d", v[3:0], v[22:18], v[17:7]), burst_gate, v[5]);
      check($sformatf("R%0d active line+%0d h=%0d", v[3:0], v[22:18], v[17:7]), active_video, v[4]);
    end

    // R5 field-start alignment to each field
    align(0, 1);
    check("R5 line after field-2 strobe 525", line_num, 263);
    check("R3 field flag 525", field, 1);
    check("R5 h after strobe", h_pos, 0);
    align(1, 1);
    check("R5 line after field-2 strobe 625", line_num, 313);
    check("R3 field flag 625", field, 1);
    align(1, 0);
    check("R3 field flag first field", field, 0);

    // R2 line wrap in both standards
    align(0, 0);
    repeat (1715) @(posedge clk);
    @(negedge clk);
    check("R2 last pixel 525", h_pos, 1715);
    @(negedge clk);
    check("R2 wrap 525 h", h_pos, 0);
    check("R2 wrap 525 line", line_num, 1);
    align(1, 0);
    repeat (1727) @(posedge clk);
    @(negedge clk);
    check("R2 last pixel 625", h_pos, 1727);
    @(negedge clk);
    check("R2 wrap 625 h", h_pos, 0);
    check("R2 wrap 625 line", line_num, 1);

    // R5 start-of-line strobe mid-line
    align(0, 0);
    repeat (300) @(posedge clk);
    @(negedge clk);
    sol_strobe = 1;
    @(negedge clk);
    sol_strobe = 0;
    check("R5 sol h", h_pos, 0);
    check("R5 sol line", line_num, 1);

    // R6 free-run ignores both strobes
    repeat (100) @(posedge clk);
    @(negedge clk);
    free_run = 1;
    begin
      int h0;
      h0 = h_pos;
      sol_strobe = 1; sof_strobe = 1; sof_field = 1;
      @(negedge clk);
      sol_strobe = 0; sof_strobe = 0;
      check("R6 h keeps counting", h_pos, h0 + 1);
      check("R6 line unchanged", line_num, 1);
      check("R6 field unchanged", field, 0);
    end

    finish_run();
  end
endmodule